// File: doc/BRIEF.md
# Latched Burst Duty Cycle Generator

This block gates an isolated power converter on and off in bursts. Each burst period is fixed at fifteen equal slots. A slot-tick input from a timing source outside the block marks the slot boundaries. The gate output is high for an even number of leading slots in every period. That number is set by one of seven duty settings, and a higher setting gives a longer on-time.

The setting is taken from a 3-bit selection code and a valid flag on the first clock after power-on reset is released. It then stays frozen until the next power-on reset, and later activity on the selection inputs has no effect. A zero code or a low valid flag selects the lowest duty. The captured setting is brought out so that it can be observed.

Top module: `burst_duty_gen`

## Requirements
- R1: While `rstN` is low, `burstEn` is 0 and `settingOut` is 0, whatever the other inputs do.
- R2: On the first rising clock edge with `rstN` high, a code of 1 to 7 with `selValid` = 1 is captured, and `settingOut` then equals that code.
- R3: If `selValid` = 0 or the code is 0 at that capture edge, `settingOut` becomes 1, the lowest setting.
- R4: After capture, changes on `selCode` and `selValid` are ignored. `settingOut` and the gating pattern stay unchanged until the next reset.
- R5: A period is 15 slots numbered 0 to 14. The slot index advances only on edges where `slotTick` = 1 after capture, and it wraps from 14 to 0.
- R6: With setting k, `burstEn` is 1 in slots 0 to 2k-1 and 0 in slots 2k to 14. This gives duties of 2k/15 (13.3 % up to 93.3 %).
- R7: `burstEn` is 0 before capture. The first period starts at slot 0 right after the capture edge, and a `slotTick` present on the capture edge itself does not advance the slot.
- R8: Bursts repeat period after period for as long as reset stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low |
| slotTick | input | 1 | One-cycle strobe marking a slot boundary |
| selCode | input | 3 | Duty selection code |
| selValid | input | 1 | Selection code is valid |
| burstEn | output | 1 | Burst gate to the converter |
| settingOut | output | 3 | Captured setting (0 before capture) |

## Verification
The captured setting appears on `settingOut` one edge after reset is released. `burstEn` follows the slot counter without further delay, so a tick on edge n changes the gate right after edge n. The bench drives inputs on the falling edge. After each rising edge it updates a model slot counter, and it compares both outputs at the following falling edge. Because of this, every result is checked in the same cycle in which it first becomes due.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;  // latch the selection this cycle
    logic run;      // setting is latched, gating active
    logic advance;  // move to next slot
    logic wrap;     // current slot is the last of the period
  } burstStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int SLOT_COUNT = 15,
  localparam int SLOT_W = $clog2(SLOT_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotTick,
  input  logic [SLOT_W-1:0] slotIdx,
  output burstStrobes_t     strobes
);
  logic captured;
  logic lastSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) captured <= 1'b0;
    else if (!captured) captured <= 1'b1;
  end

  assign lastSlot = (slotIdx == SLOT_W'(SLOT_COUNT - 1));

  always_comb begin
    strobes.capture = !captured;
    strobes.run     = captured;
    strobes.advance = captured && slotTick;
    strobes.wrap    = captured && slotTick && lastSlot;
  end
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int CODE_W       = 3,
  parameter int NUM_SETTINGS = 7,
  localparam int SET_W      = $clog2(NUM_SETTINGS + 1),
  localparam int SLOT_COUNT = 2 * NUM_SETTINGS + 1,
  localparam int SLOT_W     = $clog2(SLOT_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStrobes_t     strobes,
  input  logic [CODE_W-1:0] selCode,
  input  logic              selValid,
  output logic [SLOT_W-1:0] slotIdx,
  output logic [SET_W-1:0]  settingOut,
  output logic              burstEn
);
  logic [SET_W-1:0]  mappedSetting;
  logic [CODE_W:0]   wideCode;
  logic              codeInRange;
  logic [SLOT_W:0]   onSlots;

  // Out-of-range or unqualified codes fall back to the lowest setting
  always_comb begin
    wideCode      = {1'b0, selCode};
    codeInRange   = selValid && (wideCode != '0) &&
                    (wideCode <= (CODE_W + 1)'(NUM_SETTINGS));
    mappedSetting = codeInRange ? SET_W'(selCode) : SET_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) settingOut <= '0;
    else if (strobes.capture) settingOut <= mappedSetting;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotIdx <= '0;
    else if (strobes.wrap) slotIdx <= '0;
    else if (strobes.advance) slotIdx <= slotIdx + SLOT_W'(1);
  end

  // On-time is twice the setting, in slots
  assign onSlots = (SLOT_W + 1)'(settingOut) << 1;
  assign burstEn = strobes.run && ({1'b0, slotIdx} < onSlots);
endmodule

// File: rtl/burst_duty_gen.sv
module burst_duty_gen
  import burst_pkg::*;
#(
  parameter int CODE_W       = 3,
  parameter int NUM_SETTINGS = 7,
  localparam int SET_W = $clog2(NUM_SETTINGS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotTick,
  input  logic [CODE_W-1:0] selCode,
  input  logic              selValid,
  output logic              burstEn,
  output logic [SET_W-1:0]  settingOut
);
  localparam int SLOT_COUNT = 2 * NUM_SETTINGS + 1;
  localparam int SLOT_W     = $clog2(SLOT_COUNT);

  burstStrobes_t     strobes;
  logic [SLOT_W-1:0] slotIdx;

  burst_ctrl #(.SLOT_COUNT(SLOT_COUNT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .slotTick (slotTick),
    .slotIdx  (slotIdx),
    .strobes  (strobes)
  );

  burst_datapath #(.CODE_W(CODE_W), .NUM_SETTINGS(NUM_SETTINGS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .selCode    (selCode),
    .selValid   (selValid),
    .slotIdx    (slotIdx),
    .settingOut (settingOut),
    .burstEn    (burstEn)
  );
endmodule

// File: rtl/burst_duty_gen_chk.sv
module burst_duty_gen_chk #(
  parameter int SET_W      = 3,
  parameter int SLOT_COUNT = 15,
  parameter int SLOT_W     = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              slotTick,
  input logic              burstEn,
  input logic [SET_W-1:0]  settingOut,
  input logic [SLOT_W-1:0] slotIdx
);
  // R2
  capture_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    settingOut == '0 |=> settingOut != '0);

  // R4
  frozen_setting_chk: assert property (@(posedge clk) disable iff (!rstN)
    settingOut != '0 |=> $stable(settingOut));

  // R7
  idle_before_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    settingOut == '0 |-> !burstEn);

  // R5
  hold_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !slotTick |=> $stable(slotIdx));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (settingOut != '0 && slotTick && slotIdx == SLOT_W'(SLOT_COUNT - 1)) |=> slotIdx == '0);

  // R6
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(burstEn) |-> $past(slotTick));

  // R6
  period_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    (settingOut != '0 && slotIdx == '0) |-> burstEn);
endmodule

bind burst_duty_gen burst_duty_gen_chk #(
  .SET_W(SET_W), .SLOT_COUNT(SLOT_COUNT), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .slotTick(slotTick), .burstEn(burstEn),
  .settingOut(settingOut), .slotIdx(slotIdx)
);

// File: tb/tb_burst_duty_gen.sv
module tb_burst_duty_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       slotTick = 1'b0;
  logic [2:0] selCode = '0;
  logic       selValid = 1'b0;
  logic       burstEn;
  logic [2:0] settingOut;

  int checks = 0;
  int fails  = 0;

  burst_duty_gen dut (
    .clk(clk), .rstN(rstN), .slotTick(slotTick), .selCode(selCode),
    .selValid(selValid), .burstEn(burstEn), .settingOut(settingOut)
  );

  always #5 clk = ~clk;

  function automatic int expSetting(input int code, input bit valid);
    return (valid && code != 0) ? code : 1;
  endfunction

  function automatic bit expGate(input int k, input int slot);
    return slot < 2 * k;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic trial(input int code, input bit valid, input int tickPct, input int cycles);
    int k;
    int slot;
    int wraps;
    bit tick;
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < 3; i++) begin
      slotTick = 1'($urandom % 2); selCode = 3'($urandom); selValid = 1'($urandom);
      @(negedge clk);
      check("R1 burstEn in reset", int'(burstEn), 0);
      check("R1 settingOut in reset", int'(settingOut), 0);
    end
    selCode = 3'(code); selValid = valid; slotTick = 1'b1; rstN = 1'b1;
    k = expSetting(code, valid);
    slot = 0;
    wraps = 0;
    @(negedge clk);
    check((valid && code != 0) ? "R2 captured setting" : "R3 fallback setting",
          int'(settingOut), k);
    check("R7 first slot gated on, capture tick ignored", int'(burstEn), 1);
    for (int c = 0; c < cycles; c++) begin
      tick = (($urandom % 100) < tickPct);
      slotTick = tick; selCode = 3'($urandom); selValid = 1'($urandom);
      @(posedge clk);
      if (tick) begin
        if (slot == 14) begin slot = 0; wraps++; end
        else slot++;
      end
      @(negedge clk);
      check(wraps > 0 ? "R8 repeated period gate" : "R6 gate pattern",
            int'(burstEn), int'(expGate(k, slot)));
      check("R4 setting frozen", int'(settingOut), k);
    end
    check("R5 periods wrapped", int'(wraps > 0), 1);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // directed corners: lowest, highest, zero code, invalid flag
    trial(1, 1'b1, 100, 40);
    trial(7, 1'b1, 100, 40);
    trial(0, 1'b1, 100, 40);
    trial(7, 1'b0, 60, 80);
    for (int code = 2; code <= 6; code++) trial(code, 1'b1, 50, 100);
    for (int r = 0; r < 6; r++) trial(int'($urandom % 8), 1'($urandom), 30 + int'($urandom % 70), 150);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule